// File: doc/BRIEF.md
# Jump and Branch Next-PC Unit

This block works out where a small microcontroller core fetches next after each instruction. For every instruction it is given, it computes the next program counter value. It also reports whether control was transferred and how many cycles the instruction occupies. Its inputs are the current PC, the first instruction word, the word that follows it, the 16-bit Z pointer and three status flags: zero, carry and sign. Results are registered and appear one clock after the request.

The supported transfers are:
- a PC-relative jump with a 12-bit word offset;
- a two-word absolute jump carrying a 22-bit target;
- an indirect jump through Z;
- conditional branches with a 7-bit offset, testing zero, carry or sign, each either set or clear.

Any other instruction simply advances the PC. Two-word data-memory loads and stores advance it by two.

Top module: `jbu_next_pc`

## Requirements
- R1: While `rst` is high at a clock edge, `out_valid`, `taken_o`, `npc_o` and `cycles_o` are all cleared to zero at that edge.
- R2: A request sampled with `in_valid` high produces its result at the next clock edge, with `out_valid` high for exactly that one cycle. `out_valid` is low after any edge at which `in_valid` was low.
- R3: A word matching `1100 kkkk kkkk kkkk` is a relative jump. It gives `npc_o = pc + k + 1`, where k is bits 11:0 taken as signed, with `taken_o = 1` and `cycles_o = 2`.
- R4: A word matching `1001 010a aaaa 110a` is an absolute jump. Its target is {bits 8:4, bit 0, the whole second word}, a 22-bit value; it reports `taken_o = 1` and `cycles_o = 3`.
- R5: The exact word `16'h9409` is an indirect jump. `npc_o` takes the Z value in its low 16 bits with the upper PC bits zero; it reports `taken_o = 1` and `cycles_o = 2`.
- R6: A word matching `1111 0Pkk kkkk ksss` is a conditional branch. With P = 0 it is taken when the selected flag is 1; with P = 1 it is taken when the flag is 0. A taken branch gives `npc_o = pc + k + 1` (k is bits 9:3, signed), `taken_o = 1` and `cycles_o = 2`.
- R7: A branch that is not taken gives `npc_o = pc + 1`, `taken_o = 0` and `cycles_o = 1`.
- R8: In a branch, select value 3'b001 tests the zero flag, 3'b000 the carry flag and 3'b100 the sign flag. The two flags not selected have no effect on the outcome.
- R9: Both offsets are sign-extended to the PC width before the addition, and every PC sum wraps modulo 2^PC_W.
- R10: Any word that is not a transfer advances the PC by 1, reporting `taken_o = 0` and `cycles_o = 1`. A branch word with a select value other than 000, 001 or 100 is treated the same way.
- R11: Words matching `1001 00xd dddd 0000` are two-word data-memory loads and stores. They advance the PC by 2, with `taken_o = 0` and `cycles_o = 1`.
- R12: While `in_valid` is low, `npc_o`, `taken_o` and `cycles_o` keep their last values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Request qualifier |
| pc_i | input | PC_W | Address of the current instruction |
| insn_i | input | 16 | First instruction word |
| insn2_i | input | 16 | Following instruction word |
| zptr_i | input | Z_W | Z pointer register |
| flag_z | input | 1 | Zero flag |
| flag_c | input | 1 | Carry flag |
| flag_s | input | 1 | Sign flag |
| out_valid | output | 1 | Result valid |
| npc_o | output | PC_W | Next program counter |
| taken_o | output | 1 | Control was transferred |
| cycles_o | output | 2 | Cycle cost of the instruction |

## Verification
The bench builds the block with its defaults, PC_W = 22 and Z_W = 16. These values make the full 22-bit absolute target reachable, including all six of its high bits taken from the first word. They also put wrap-around within reach: a relative jump forward from the top address and a branch backward from address zero both cross the 2^22 boundary. Offsets at their extremes (-2048, +2047 and -64) exercise sign extension across the full width.

// File: rtl/jbu_pkg.sv
package jbu_pkg;
  localparam int INSN_W   = 16;
  localparam int REL_W    = 12;
  localparam int BR_W     = 7;
  localparam int ABS_HI_W = 6;
  localparam int CYC_W    = 2;

  typedef enum logic [2:0] {
    K_SEQ1,
    K_SEQ2,
    K_RJMP,
    K_JMP,
    K_IJMP,
    K_BR
  } kind_t;

  typedef enum logic [2:0] {
    SEL_C = 3'b000,
    SEL_Z = 3'b001,
    SEL_S = 3'b100
  } fsel_t;
endpackage

// File: rtl/jbu_decode.sv
module jbu_decode
  import jbu_pkg::*;
(
  input  logic [INSN_W-1:0] insn,
  output kind_t             kind,
  output logic [2:0]        sel,
  output logic              pol_clear
);
  logic is_rjmp, is_jmp, is_ijmp, is_brf, is_two, sel_ok;

  assign sel       = insn[2:0];
  assign pol_clear = insn[10];
  assign sel_ok    = (sel == SEL_C) || (sel == SEL_Z) || (sel == SEL_S);

  assign is_rjmp = (insn[15:12] == 4'b1100);
  assign is_jmp  = (insn[15:9] == 7'b1001010) && (insn[3:1] == 3'b110);
  assign is_ijmp = (insn == 16'h9409);
  assign is_brf  = (insn[15:11] == 5'b11110) && sel_ok;
  assign is_two  = (insn[15:10] == 6'b100100) && (insn[3:0] == 4'b0000);

  always_comb begin
    if (is_rjmp)      kind = K_RJMP;
    else if (is_jmp)  kind = K_JMP;
    else if (is_ijmp) kind = K_IJMP;
    else if (is_brf)  kind = K_BR;
    else if (is_two)  kind = K_SEQ2;
    else              kind = K_SEQ1;
  end
endmodule

// File: rtl/jbu_cond.sv
module jbu_cond
  import jbu_pkg::*;
(
  input  logic [2:0] sel,
  input  logic       pol_clear,
  input  logic       flag_z,
  input  logic       flag_c,
  input  logic       flag_s,
  output logic       take
);
  logic flag;

  always_comb begin
    case (sel)
      SEL_Z:   flag = flag_z;
      SEL_S:   flag = flag_s;
      default: flag = flag_c;
    endcase
  end

  assign take = flag ^ pol_clear;
endmodule

// File: rtl/jbu_target.sv
module jbu_target
  import jbu_pkg::*;
#(
  parameter int PC_W = 22,
  parameter int Z_W  = 16
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [INSN_W-1:0] insn,
  input  logic [INSN_W-1:0] insn2,
  input  logic [Z_W-1:0]    zptr,
  output logic [PC_W-1:0]   rel_tgt,
  output logic [PC_W-1:0]   br_tgt,
  output logic [PC_W-1:0]   abs_tgt,
  output logic [PC_W-1:0]   ind_tgt,
  output logic [PC_W-1:0]   inc1,
  output logic [PC_W-1:0]   inc2
);
  localparam int ABS_W = ABS_HI_W + INSN_W;

  logic [PC_W-1:0]  rel_ext, br_ext;
  logic [ABS_W-1:0] abs_raw;

  assign rel_ext = {{(PC_W-REL_W){insn[REL_W-1]}}, insn[REL_W-1:0]};
  assign br_ext  = {{(PC_W-BR_W){insn[9]}}, insn[9:3]};
  assign abs_raw = {insn[8:4], insn[0], insn2};

  assign inc1    = pc + PC_W'(1);
  assign inc2    = pc + PC_W'(2);
  assign rel_tgt = inc1 + rel_ext;
  assign br_tgt  = inc1 + br_ext;
  assign abs_tgt = PC_W'(abs_raw);
  assign ind_tgt = PC_W'(zptr);
endmodule

// File: rtl/jbu_next_pc.sv
module jbu_next_pc
  import jbu_pkg::*;
#(
  parameter int PC_W = 22,
  parameter int Z_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [PC_W-1:0]   pc_i,
  input  logic [15:0]       insn_i,
  input  logic [15:0]       insn2_i,
  input  logic [Z_W-1:0]    zptr_i,
  input  logic              flag_z,
  input  logic              flag_c,
  input  logic              flag_s,
  output logic              out_valid,
  output logic [PC_W-1:0]   npc_o,
  output logic              taken_o,
  output logic [1:0]        cycles_o
);
  kind_t            kind;
  logic [2:0]       sel;
  logic             pol_clear, take;
  logic [PC_W-1:0]  rel_tgt, br_tgt, abs_tgt, ind_tgt, inc1, inc2;
  logic [PC_W-1:0]  nxt;
  logic             nxt_tk;
  logic [CYC_W-1:0] nxt_cyc;

  jbu_decode u_dec (
    .insn(insn_i), .kind(kind), .sel(sel), .pol_clear(pol_clear)
  );

  jbu_cond u_cond (
    .sel(sel), .pol_clear(pol_clear),
    .flag_z(flag_z), .flag_c(flag_c), .flag_s(flag_s), .take(take)
  );

  jbu_target #(.PC_W(PC_W), .Z_W(Z_W)) u_tgt (
    .pc(pc_i), .insn(insn_i), .insn2(insn2_i), .zptr(zptr_i),
    .rel_tgt(rel_tgt), .br_tgt(br_tgt), .abs_tgt(abs_tgt),
    .ind_tgt(ind_tgt), .inc1(inc1), .inc2(inc2)
  );

  always_comb begin
    nxt     = inc1;
    nxt_tk  = 1'b0;
    nxt_cyc = CYC_W'(1);
    case (kind)
      K_RJMP: begin nxt = rel_tgt; nxt_tk = 1'b1; nxt_cyc = CYC_W'(2); end
      K_JMP:  begin nxt = abs_tgt; nxt_tk = 1'b1; nxt_cyc = CYC_W'(3); end
      K_IJMP: begin nxt = ind_tgt; nxt_tk = 1'b1; nxt_cyc = CYC_W'(2); end
      K_BR: begin
        if (take) begin
          nxt = br_tgt; nxt_tk = 1'b1; nxt_cyc = CYC_W'(2);
        end
      end
      K_SEQ2:  nxt = inc2;
      default: nxt = inc1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      npc_o     <= '0;
      taken_o   <= 1'b0;
      cycles_o  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        npc_o    <= nxt;
        taken_o  <= nxt_tk;
        cycles_o <= nxt_cyc;
      end
    end
  end

  assert_valid_follows_R2: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  assert_valid_drops_R2: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  assert_taken_cost_R6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && taken_o) |-> (cycles_o >= 2'd2));
  assert_seq_cost_R7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !taken_o) |-> (cycles_o == 2'd1));
  assert_ind_target_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && insn_i == 16'h9409) |=> (npc_o == PC_W'($past(zptr_i))));
  assert_hold_R12: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(npc_o) && $stable(cycles_o)));
endmodule

// File: tb/sim_jbu_next_pc.sv
module sim_jbu_next_pc;
  localparam int PC_W = 22;
  localparam int Z_W  = 16;
  localparam int NV   = 28;

  // {pc, insn, insn2, z, {S,C,Z}, exp_npc, exp_taken, exp_cycles}
  localparam logic [97:0] VEC [NV] = '{
    {22'h000100,16'hC005,16'h0000,16'h0000,3'b000,22'h000106,1'b1,2'd2}, // R3
    {22'h000100,16'hCFFF,16'h0000,16'h0000,3'b000,22'h000100,1'b1,2'd2}, // R3 R9
    {22'h000010,16'hC800,16'h0000,16'h0000,3'b000,22'h3FF811,1'b1,2'd2}, // R9
    {22'h3FFFFF,16'hC7FF,16'h0000,16'h0000,3'b000,22'h0007FF,1'b1,2'd2}, // R9
    {22'h000050,16'h940C,16'h1234,16'h0000,3'b000,22'h001234,1'b1,2'd3}, // R4
    {22'h000050,16'h95FD,16'hABCD,16'h0000,3'b000,22'h3FABCD,1'b1,2'd3}, // R4
    {22'h3F0000,16'h9409,16'h0000,16'hBEEF,3'b000,22'h00BEEF,1'b1,2'd2}, // R5
    {22'h000200,16'hF019,16'h0000,16'h0000,3'b001,22'h000204,1'b1,2'd2}, // R6
    {22'h000200,16'hF019,16'h0000,16'h0000,3'b000,22'h000201,1'b0,2'd1}, // R7
    {22'h000200,16'hF419,16'h0000,16'h0000,3'b000,22'h000204,1'b1,2'd2}, // R6
    {22'h000200,16'hF419,16'h0000,16'h0000,3'b001,22'h000201,1'b0,2'd1}, // R7
    {22'h000200,16'hF3F8,16'h0000,16'h0000,3'b010,22'h000200,1'b1,2'd2}, // R6 R8
    {22'h000200,16'hF7F8,16'h0000,16'h0000,3'b010,22'h000201,1'b0,2'd1}, // R7 R8
    {22'h000200,16'hF204,16'h0000,16'h0000,3'b100,22'h0001C1,1'b1,2'd2}, // R6 R8
    {22'h000200,16'hF604,16'h0000,16'h0000,3'b000,22'h0001C1,1'b1,2'd2}, // R6
    {22'h000200,16'hF604,16'h0000,16'h0000,3'b100,22'h000201,1'b0,2'd1}, // R7
    {22'h000000,16'hF3F0,16'h0000,16'h0000,3'b010,22'h3FFFFF,1'b1,2'd2}, // R9
    {22'h000200,16'hF019,16'h0000,16'h0000,3'b110,22'h000201,1'b0,2'd1}, // R8
    {22'h000200,16'hF3F8,16'h0000,16'h0000,3'b101,22'h000201,1'b0,2'd1}, // R8
    {22'h000200,16'hF204,16'h0000,16'h0000,3'b011,22'h000201,1'b0,2'd1}, // R8
    {22'h000300,16'h0C12,16'h0000,16'h0000,3'b111,22'h000301,1'b0,2'd1}, // R10
    {22'h000300,16'h9100,16'h0000,16'h0000,3'b000,22'h000302,1'b0,2'd1}, // R11
    {22'h000300,16'h9300,16'h0000,16'h0000,3'b000,22'h000302,1'b0,2'd1}, // R11
    {22'h000300,16'hF01A,16'h0000,16'h0000,3'b111,22'h000301,1'b0,2'd1}, // R10
    {22'h000300,16'h9408,16'h0000,16'hFFFF,3'b000,22'h000301,1'b0,2'd1}, // R10
    {22'h3FFFFF,16'h0C12,16'h0000,16'h0000,3'b000,22'h000000,1'b0,2'd1}, // R10 R9
    {22'h3FFFFE,16'h9100,16'h0000,16'h0000,3'b000,22'h000000,1'b0,2'd1}, // R11 R9
    {22'h000400,16'h9409,16'h0000,16'h0042,3'b111,22'h000042,1'b1,2'd2}  // R5
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0;
  logic [PC_W-1:0] pc_i = '0;
  logic [15:0] insn_i = '0, insn2_i = '0;
  logic [Z_W-1:0] zptr_i = '0;
  logic flag_z = 1'b0, flag_c = 1'b0, flag_s = 1'b0;
  logic out_valid, taken_o;
  logic [PC_W-1:0] npc_o;
  logic [1:0] cycles_o;
  int checks = 0;
  int errors = 0;
  int cyc_cnt = 0;

  always #2.5 clk = ~clk;

  jbu_next_pc #(.PC_W(PC_W), .Z_W(Z_W)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .pc_i(pc_i),
    .insn_i(insn_i), .insn2_i(insn2_i), .zptr_i(zptr_i),
    .flag_z(flag_z), .flag_c(flag_c), .flag_s(flag_s),
    .out_valid(out_valid), .npc_o(npc_o), .taken_o(taken_o),
    .cycles_o(cycles_o)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [97:0] v);
    @(negedge clk);
    pc_i = v[97:76]; insn_i = v[75:60]; insn2_i = v[59:44]; zptr_i = v[43:28];
    flag_s = v[27]; flag_c = v[26]; flag_z = v[25];
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc_cnt++;
    if (cyc_cnt > 100000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 100000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 out_valid", 32'(out_valid), 0);
    chk("R1 npc", 32'(npc_o), 0);
    chk("R1 taken", 32'(taken_o), 0);
    chk("R1 cycles", 32'(cycles_o), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      chk($sformatf("vec%0d valid R2", i), 32'(out_valid), 1);
      chk($sformatf("vec%0d npc R3-R11", i), 32'(npc_o), 32'(VEC[i][24:3]));
      chk($sformatf("vec%0d taken", i), 32'(taken_o), 32'(VEC[i][2]));
      chk($sformatf("vec%0d cycles", i), 32'(cycles_o), 32'(VEC[i][1:0]));
    end

    // R2 and R12: valid drops, values hold with in_valid low
    apply(VEC[5]);
    @(negedge clk);
    chk("R2 valid low", 32'(out_valid), 0);
    chk("R12 npc hold", 32'(npc_o), 32'h3FABCD);
    chk("R12 cycles hold", 32'(cycles_o), 3);
    pc_i = 22'h000001; insn_i = 16'hC005;
    @(negedge clk);
    chk("R12 npc hold after input change", 32'(npc_o), 32'h3FABCD);
    chk("R12 taken hold", 32'(taken_o), 1);

    // R1: synchronous reset mid-run
    apply(VEC[0]);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-run valid", 32'(out_valid), 0);
    chk("R1 mid-run npc", 32'(npc_o), 0);
    chk("R1 mid-run cycles", 32'(cycles_o), 0);
    rst = 1'b0;

    // R2: back-to-back requests
    @(negedge clk);
    pc_i = 22'h000020; insn_i = 16'h0000; in_valid = 1'b1;
    @(negedge clk);
    chk("R2 b2b first", 32'(npc_o), 32'h21);
    pc_i = 22'h000040;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 b2b second", 32'(npc_o), 32'h41);
    chk("R2 b2b valid", 32'(out_valid), 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule